// File: doc/BRIEF.md
# Zero-Run Serial Bit Encoder

This block turns a serial bitstream into a stream of byte codes. Each code counts the zero bits that came before a one bit. A one bit that follows N zeros, with N no larger than 254, produces the byte N. A run of zeros that reaches 255 with no one bit produces the reserved byte 255 at once. The zero count then starts again from nothing. This suits data made mostly of long zero stretches. The bytes are ready to go to a later entropy coder.

Bits enter one per handshake on a valid/ready port, and a last flag marks the final bit of a stream. Codes leave one per handshake on a byte-wide valid/ready port, and a last flag marks the final code. A single output slot sits between the two ports. While that slot holds a code the consumer has not taken, the input port stalls.

Top module: `zrle_encoder`

## Requirements
- R1: An accepted one bit that follows N zeros (0 to 254) loads the output with code N on the next clock edge, and the zero count returns to 0.
- R2: When an accepted zero bit makes 255 consecutive zeros, code 255 is loaded on the next edge and the count returns to 0. No one bit is implied by this code.
- R3: The bit sequence 00100000101000000000010000011000000000001, taken left to right with the last flag on the final bit, yields the codes 2,5,1,10,5,0,11.
- R4: A one bit that directly follows another one bit yields code 0.
- R5: A final bit (in_last high) of value 0 yields code 255 with out_last high, whatever the pending count. A final bit of value 1 yields its count code with out_last high. Either way the count is 0 for the next stream.
- R6: While out_valid is high and out_ready is low, in_ready is low, and out_code and out_last hold their values.
- R7: A zero bit that neither completes a 255 run nor carries in_last produces no code, and in_ready is high whenever the slot is empty.
- R8: A synchronous reset (rst high at a clock edge) empties the output slot and clears the zero count.
- R9: out_last is high only on the code produced by a bit that carried in_last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Encoder can take the bit this cycle |
| in_bit | input | 1 | Serial data bit |
| in_last | input | 1 | Bit is the final one of its stream |
| out_valid | output | 1 | Code byte available |
| out_ready | input | 1 | Consumer takes the code this cycle |
| out_code | output | 8 | Zero-run code |
| out_last | output | 1 | Code is the final one of its stream |

## Verification
The assertions assume that the consumer follows the valid/ready rule. They also assume that in_bit and in_last matter only in cycles where in_valid and in_ready are both high. Reset is taken to be held for at least one clock edge from time zero. The stimulus changes every input only at the falling edge. It draws valid and ready from $urandom with a fixed seed. Random streams vary their zero density so that saturating runs, adjacent ones and trailing zeros all occur. Directed streams cover the exact 255-zero boundary and a reset issued while a code is waiting.

// File: rtl/zr_pkg.sv
package zr_pkg;
    localparam int ZR_CODE_W = 8;
    typedef logic [ZR_CODE_W-1:0] zr_code_t;

    typedef struct packed {
        logic     last;
        zr_code_t code;
    } zr_emit_t;
endpackage

// File: rtl/zr_run_counter.sv
module zr_run_counter
    import zr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take_i,
    input  logic     bit_i,
    input  logic     last_i,
    output logic     emit_o,
    output zr_emit_t emit_data_o
);
    localparam zr_code_t SAT_CODE = '1;
    localparam zr_code_t SAT_EDGE = SAT_CODE - zr_code_t'(1);

    typedef struct packed {
        zr_code_t cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        emit_o      = 1'b0;
        emit_data_o = '0;
        if (take_i) begin
            if (bit_i) begin
                emit_o           = 1'b1;
                emit_data_o.code = st_q.cnt;
                emit_data_o.last = last_i;
                st_d.cnt         = '0;
            end else if (st_q.cnt == SAT_EDGE || last_i) begin
                // run saturated, or stream closed on pending zeros
                emit_o           = 1'b1;
                emit_data_o.code = SAT_CODE;
                emit_data_o.last = last_i;
                st_d.cnt         = '0;
            end else begin
                st_d.cnt = st_q.cnt + zr_code_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/zr_out_slot.sv
module zr_out_slot
    import zr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  zr_emit_t load_data_i,
    input  logic     pop_i,
    output logic     valid_o,
    output zr_emit_t data_o,
    output logic     room_o
);
    typedef struct packed {
        logic     valid;
        zr_emit_t data;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        sl_d   = sl_q;
        room_o = !sl_q.valid || pop_i;
        if (sl_q.valid && pop_i) sl_d.valid = 1'b0;
        if (load_i) begin
            sl_d.valid = 1'b1;
            sl_d.data  = load_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sl_q <= '0;
        else     sl_q <= sl_d;
    end

    assign valid_o = sl_q.valid;
    assign data_o  = sl_q.data;
endmodule

// File: rtl/zrle_encoder.sv
module zrle_encoder
    import zr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_bit,
    input  logic                 in_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ZR_CODE_W-1:0] out_code,
    output logic                 out_last
);
    logic     take, emit, room;
    zr_emit_t emit_data, slot_data;

    assign take     = in_valid && room;
    assign in_ready = room;

    zr_run_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take),
        .bit_i       (in_bit),
        .last_i      (in_last),
        .emit_o      (emit),
        .emit_data_o (emit_data)
    );

    zr_out_slot u_slot (
        .clk         (clk),
        .rst         (rst),
        .load_i      (emit),
        .load_data_i (emit_data),
        .pop_i       (out_ready),
        .valid_o     (out_valid),
        .data_o      (slot_data),
        .room_o      (room)
    );

    assign out_code = slot_data.code;
    assign out_last = slot_data.last;
endmodule

// File: rtl/zr_checker.sv
module zr_checker
    import zr_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 in_bit,
    input logic                 in_last,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [ZR_CODE_W-1:0] out_code,
    input logic                 out_last
);
    p_one_loads_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_bit) |=> out_valid);

    p_last_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_bit && in_last) |=> (out_valid && out_last && (&out_code)));

    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_last)));

    p_ready_empty_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind zrle_encoder zr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_last  (out_last)
);

// File: tb/sim_zrle_encoder.sv
module sim_zrle_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
    logic       out_ready = 1'b0;
    logic       in_ready, out_valid, out_last;
    logic [7:0] out_code;

    int compared = 0, mismatched = 0;
    bit bits_q[$];
    bit lasts_q[$];
    logic [8:0] exp_q[$];

    always #5 clk = ~clk;

    zrle_encoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_code(out_code), .out_last(out_last)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected codes from the requirements: {last, code}
    task automatic add_stream(bit s[$]);
        int cnt = 0;
        foreach (s[i]) begin
            bit l = (i == s.size() - 1);
            bits_q.push_back(s[i]);
            lasts_q.push_back(l);
            if (s[i]) begin
                exp_q.push_back({l, 8'(cnt)}); cnt = 0;
            end else begin
                cnt++;
                if (cnt == 255 || l) begin
                    exp_q.push_back({l, 8'd255}); cnt = 0;
                end
            end
        end
    endtask

    task automatic play(int ready_pct);
        int bi = 0;
        int cyc = 0;
        while (!(bi == bits_q.size() && exp_q.size() == 0 && !out_valid)) begin
            @(negedge clk);
            out_ready = ($urandom % 100) < ready_pct;
            if (bi < bits_q.size()) begin
                in_valid = ($urandom % 4) != 0;
                in_bit   = bits_q[bi];
                in_last  = lasts_q[bi];
            end else in_valid = 1'b0;
            #1;
            if (out_valid && !out_ready) check("R6 in_ready stalls", in_ready, 0);
            if (!out_valid) check("R7 ready when empty", in_ready, 1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) check("R7 unexpected code", out_code, 999);
                else begin
                    logic [8:0] e = exp_q.pop_front();
                    check(e[7:0] == 8'd255 ? "R2 code" : "R1 code", out_code, e[7:0]);
                    check("R9 last flag", out_last, e[8]);
                end
            end
            if (in_valid && in_ready) bi++;
            if (++cyc > 40000) begin
                check("play timeout", 1, 0);
                break;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        bits_q.delete(); lasts_q.delete(); exp_q.delete();
    endtask

    function automatic void push_str(string s, ref bit q[$]);
        foreach (s[i]) q.push_back(s[i] == "1");
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual expired expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        bit s[$];
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R8 reset out_valid", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset in_ready", in_ready, 1);

        // R3 worked example, codes compared with model and checked literally
        push_str("00100000101000000000010000011000000000001", s);
        add_stream(s);
        check("R3 expected list", {exp_q[0][7:0], exp_q[1][7:0], exp_q[6][7:0]}, {8'd2, 8'd5, 8'd11});
        play(70); s.delete();

        // R4 adjacent ones
        push_str("0111", s); add_stream(s); play(50); s.delete();

        // R2 exactly 255 zeros then one, and 600 zeros then one
        repeat (255) s.push_back(0); s.push_back(1); add_stream(s); play(60); s.delete();
        repeat (600) s.push_back(0); s.push_back(1); add_stream(s); play(90); s.delete();

        // R5 trailing zeros, and a lone final zero
        push_str("1000", s); add_stream(s); play(40); s.delete();
        push_str("0", s); add_stream(s); play(100); s.delete();

        // R7 zeros without last produce nothing; R8 reset clears count
        in_valid = 1'b1; in_bit = 1'b0; in_last = 1'b0; out_ready = 1'b1;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 no code for zeros", out_valid, 0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        push_str("1", s); add_stream(s); play(100); s.delete();

        // R8 reset drops a waiting code
        out_ready = 1'b0; in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 code waiting", out_valid, 1);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R8 slot emptied", out_valid, 0);

        // random streams of varied zero density
        for (int n = 0; n < 24; n++) begin
            int len = 20 + ($urandom % 300);
            int pct = (n % 4 == 0) ? 1 : 5 + ($urandom % 50);
            for (int k = 0; k < len; k++) s.push_back(($urandom % 100) < pct);
            add_stream(s); play(30 + ($urandom % 70)); s.delete();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule